// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N and produces one feedback pulse per N input cycles. The division is built from a prescaler that alternates between moduli P+1 and P, a swallow counter that sets how many prescaler periods use the larger modulus, and a main counter that sets the total number of prescaler periods. The resulting ratio is N = P·B + A, where A is the swallow count and B is the main count. The prescaler is modelled as a synchronous counter clocked by the same input clock.

New A and B values arrive on a hold bus together with a one-cycle load strobe. They are checked for legality, parked in a pending register and copied into the working counters only at the boundary of a divide cycle. A divide cycle already under way therefore always completes with the values it started with. An enable input powers the counters down. While it is low the counters sit at the start of a divide cycle and no pulses appear. The parameter P (8, 16 or 32) sets the prescaler ratio and the widths of both counters.

Top module: `pulse_swallow_div`

## Requirements
- R1: With legal values A and B in effect, consecutive feedback pulses are exactly N = P·B + A enabled input cycles apart.
- R2: The feedback pulse is high for exactly one input cycle, on the last cycle of each divide cycle.
- R3: The modulus-control output is high during the first A·(P+1) cycles of each divide cycle and low for the remaining P·(B−A) cycles.
- R4: A load is legal when B ≥ 1 and B ≥ A. When a load is illegal, the error output goes high from the next cycle, the values are discarded and the running division is unchanged. A legal load clears the error output from the next cycle.
- R5: After reset the feedback pulse, the modulus control and the error output are all low, and they stay low until the first legal load. The cycle after that load is cycle 1 of the first divide cycle.
- R6: A legal load made while the divider is running is held as pending and applies from the next divide cycle. A load whose strobe coincides with the pulse cycle waits for the following boundary.
- R7: A later legal load replaces a pending value that has not yet been applied.
- R8: While the enable is low, no pulse is produced and the counters are held at the start of a divide cycle, with any pending value adopted. Loads are still accepted while the enable is low. After the enable rises, the first pulse falls on the N-th enabled cycle.
- R9: P selects the widths. The A value is log2(P) bits wide. The B value is 11 bits wide for P = 32 and 12 bits wide for P = 8 or 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Active-high enable; low holds the counters in power-down |
| load_req | input | 1 | One-cycle strobe that offers new hold values |
| a_hold | input | log2(P) | Swallow count A |
| b_hold | input | 11 or 12 | Main count B |
| fb_pulse | output | 1 | Divided feedback pulse |
| mod_ctl | output | 1 | High when the prescaler divides by P+1 |
| cfg_err | output | 1 | Last load was rejected as illegal |

## Verification
The divider is driven with boundary ratios: A = 0 (all periods use P), A = B (all periods use P+1), and B = 1 with A = 0 or 1. These ratios separate the swallow path from the main path and catch off-by-one errors in either counter. Random legal A/B pairs then confirm the P·B + A interval and the position of the modulus-control edge across many ratios. Loads are placed mid-cycle, back to back, exactly on the pulse cycle and while the enable is low. These placements distinguish pending-register timing from immediate loading. Illegal loads with B < A and with B = 0 are applied both before the first legal load and while the divider is running, to show that they are rejected without disturbing the output.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
    // width of the swallow counter for a given lower modulus
    function automatic int swallow_width(input int p);
        return $clog2(p);
    endfunction

    // width of the main counter for a given lower modulus
    function automatic int main_width(input int p);
        return (p == 32) ? 11 : 12;
    endfunction

    // width of the prescaler down-counter (counts P .. 0)
    function automatic int presc_width(input int p);
        return $clog2(p + 1);
    endfunction
endpackage

// File: rtl/psd_cfg_latch.sv
`timescale 1ns/1ps
module psd_cfg_latch #(
    parameter int AW = 5,
    parameter int BW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] a_in,
    input  logic [BW-1:0] b_in,
    input  logic          adopt,
    output logic          run_o,
    output logic [AW-1:0] nxt_a,
    output logic [BW-1:0] nxt_b,
    output logic          err_o
);
    typedef struct packed {
        logic          run;
        logic          pend;
        logic          err;
        logic [AW-1:0] pa;
        logic [AW-1:0] ca;
        logic [BW-1:0] pb;
        logic [BW-1:0] cb;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    legal;
    logic [BW-1:0] a_ext;

    always_comb begin
        a_ext = {{(BW-AW){1'b0}}, a_in};
        legal = (b_in != '0) && (b_in >= a_ext);
        st_d  = st_q;
        // boundary: pending values become the working values
        if (st_q.run && adopt && st_q.pend) begin
            st_d.ca   = st_q.pa;
            st_d.cb   = st_q.pb;
            st_d.pend = 1'b0;
        end
        if (ld) begin
            st_d.err = !legal;
            if (legal) begin
                if (!st_q.run) begin
                    st_d.run = 1'b1;
                    st_d.ca  = a_in;
                    st_d.cb  = b_in;
                end else begin
                    st_d.pend = 1'b1;
                    st_d.pa   = a_in;
                    st_d.pb   = b_in;
                end
            end
        end
        nxt_a = st_d.ca;
        nxt_b = st_d.cb;
        run_o = st_q.run;
        err_o = st_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    bad_load_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && ((b_in == '0) || (b_in < {{(BW-AW){1'b0}}, a_in}))) |=> err_o);

    // R4
    active_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> ((st_q.cb != '0) && (st_q.cb >= {{(BW-AW){1'b0}}, st_q.ca})));

    // R6
    pend_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && adopt && st_q.pend && !ld) |=> !st_q.pend);
endmodule

// File: rtl/psd_swallow_core.sv
`timescale 1ns/1ps
module psd_swallow_core #(
    parameter int P  = 32,
    parameter int AW = 5,
    parameter int BW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          run,
    input  logic [AW-1:0] nxt_a,
    input  logic [BW-1:0] nxt_b,
    output logic          wrap,
    output logic          fb_pulse,
    output logic          mod_ctl
);
    localparam int PCW = psd_pkg::presc_width(P);
    localparam logic [PCW-1:0] PC_HI = PCW'(P);
    localparam logic [PCW-1:0] PC_LO = PCW'(P - 1);

    typedef struct packed {
        logic [PCW-1:0] pc;
        logic [AW-1:0]  ar;
        logic [BW-1:0]  br;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic period_end, last_period, restart;
    logic [AW-1:0] ar_next;

    always_comb begin
        period_end  = (st_q.pc == '0);
        last_period = period_end && (st_q.br == BW'(1));
        restart     = !run || !en || last_period;
        ar_next     = (st_q.ar != '0) ? st_q.ar - AW'(1) : '0;
        st_d        = st_q;
        if (restart) begin
            st_d.ar = nxt_a;
            st_d.br = nxt_b;
            st_d.pc = (nxt_a != '0) ? PC_HI : PC_LO;
        end else if (period_end) begin
            st_d.ar = ar_next;
            st_d.br = st_q.br - BW'(1);
            st_d.pc = (ar_next != '0) ? PC_HI : PC_LO;
        end else begin
            st_d.pc = st_q.pc - PCW'(1);
        end
        wrap     = run && en && last_period;
        fb_pulse = wrap;
        mod_ctl  = run && (st_q.ar != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    // R8
    no_pulse_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !fb_pulse);

    // R3
    mod_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en && st_q.pc != '0) |=> $stable(mod_ctl));

    // R3
    mod_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && nxt_a != '0) |=> mod_ctl);
endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/1ps
module pulse_swallow_div #(
    parameter int PRESC_LOW = 32
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       en,
    input  logic                                       load_req,
    input  logic [psd_pkg::swallow_width(PRESC_LOW)-1:0] a_hold,
    input  logic [psd_pkg::main_width(PRESC_LOW)-1:0]    b_hold,
    output logic                                       fb_pulse,
    output logic                                       mod_ctl,
    output logic                                       cfg_err
);
    localparam int AW = psd_pkg::swallow_width(PRESC_LOW);
    localparam int BW = psd_pkg::main_width(PRESC_LOW);

    logic          run, wrap, adopt;
    logic [AW-1:0] nxt_a;
    logic [BW-1:0] nxt_b;

    assign adopt = wrap || !en;

    psd_cfg_latch #(.AW(AW), .BW(BW)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (load_req),
        .a_in  (a_hold),
        .b_in  (b_hold),
        .adopt (adopt),
        .run_o (run),
        .nxt_a (nxt_a),
        .nxt_b (nxt_b),
        .err_o (cfg_err)
    );

    psd_swallow_core #(.P(PRESC_LOW), .AW(AW), .BW(BW)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .run      (run),
        .nxt_a    (nxt_a),
        .nxt_b    (nxt_b),
        .wrap     (wrap),
        .fb_pulse (fb_pulse),
        .mod_ctl  (mod_ctl)
    );

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!fb_pulse && !mod_ctl));
endmodule

// File: tb/pulse_swallow_div_tb.sv
`timescale 1ns/1ps
module pulse_swallow_div_tb_top;
    localparam int P  = 32;
    localparam int AW = $clog2(P);
    localparam int BW = (P == 32) ? 11 : 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic ld = 1'b0;
    logic [AW-1:0] a_h = '0;
    logic [BW-1:0] b_h = '0;
    logic fb, mc, er;

    always #5 clk = ~clk;

    pulse_swallow_div #(.PRESC_LOW(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .load_req(ld),
        .a_hold(a_h), .b_hold(b_h),
        .fb_pulse(fb), .mod_ctl(mc), .cfg_err(er)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // behavioural reference: position inside the divide cycle
    bit m_run, m_pend, m_err, m_en;
    int m_a, m_b, m_pa, m_pb, m_pos;

    function automatic int nval(input int a, input int b);
        return P * b + a;
    endfunction

    task automatic check_out();
        bit efb, emc;
        efb = m_run && m_en && (m_pos == nval(m_a, m_b) - 1);
        emc = m_run && (m_pos < m_a * (P + 1));
        vectors++;
        if (fb !== efb) begin
            miscompares++;
            $display("FAIL R1/R2 fb_pulse act=%0b exp=%0b (A=%0d B=%0d pos=%0d)", fb, efb, m_a, m_b, m_pos);
        end
        if (mc !== emc) begin
            miscompares++;
            $display("FAIL R3 mod_ctl act=%0b exp=%0b (A=%0d B=%0d pos=%0d)", mc, emc, m_a, m_b, m_pos);
        end
        if (er !== m_err) begin
            miscompares++;
            $display("FAIL R4 cfg_err act=%0b exp=%0b", er, m_err);
        end
    endtask

    task automatic model_step(input bit e, input bit l, input int a, input int b);
        bit legal;
        if (m_run) begin
            if (e && (m_pos != nval(m_a, m_b) - 1)) m_pos++;
            else begin
                m_pos = 0;
                if (m_pend) begin m_a = m_pa; m_b = m_pb; m_pend = 0; end
            end
        end
        if (l) begin
            legal = (b != 0) && (b >= a);
            m_err = !legal;
            if (legal) begin
                if (!m_run) begin m_run = 1; m_a = a; m_b = b; m_pos = 0; end
                else begin m_pend = 1; m_pa = a; m_pb = b; end
            end
        end
        m_en = e;
    endtask

    task automatic tick(input bit e, input bit l, input int a, input int b,
                        input bit on_pulse, output bit did);
        @(negedge clk);
        check_out();
        did = l && (!on_pulse || fb);
        en  = e;
        ld  = did;
        a_h = AW'(a);
        b_h = BW'(b);
        model_step(e, did, a, b);
    endtask

    task automatic run_n(input int n, input bit e);
        bit d;
        for (int i = 0; i < n; i++) tick(e, 0, 0, 0, 0, d);
    endtask

    task automatic load_now(input bit e, input int a, input int b);
        bit d;
        tick(e, 1, a, b, 0, d);
    endtask

    task automatic load_at_wrap(input int a, input int b);
        bit d = 0;
        for (int i = 0; i < 70000 && !d; i++) tick(1, 1, a, b, 1, d);
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R5: quiet after reset, no pulses before a legal load
        run_n(20, 1);
        // R4: illegal loads while idle (B<A, then B=0) are rejected
        load_now(1, 7, 3);
        run_n(10, 1);
        load_now(1, 0, 0);
        run_n(10, 1);
        // R1 R2 R3 R5: first legal load starts division
        load_now(1, 5, 40);
        run_n(3 * nval(5, 40) + 7, 1);
        // R4: illegal load while running leaves the ratio intact, legal clears flag
        load_now(1, 20, 10);
        run_n(nval(5, 40) + 3, 1);
        // R6: mid-cycle load is pending until the boundary
        load_now(1, 31, 31);
        run_n(2 * nval(31, 31) + 50, 1);
        // R7: second load overrides the first before the boundary
        run_n(100, 1);
        load_now(1, 0, 2);
        run_n(3, 1);
        load_now(1, 1, 1);
        run_n(3 * nval(31, 31), 1);
        // R6: load exactly on the pulse cycle waits one more divide cycle
        load_at_wrap(0, 1);
        run_n(3 * nval(1, 1) + 70, 1);
        load_at_wrap(3, 9);
        run_n(3 * nval(3, 9), 1);
        // R8: enable low mid-cycle, load while disabled, then resume
        run_n(37, 1);
        run_n(25, 0);
        load_now(0, 12, 20);
        run_n(8, 0);
        run_n(3 * nval(12, 20) + 5, 1);
        // R8: pulse suppressed when enable drops near the boundary
        run_n(nval(12, 20) - 3, 1);
        run_n(10, 0);
        run_n(nval(12, 20) + 10, 1);
        // R1 R3 R9: random legal ratios across the full swallow range
        for (int k = 0; k < 15; k++) begin
            int ra, rb;
            ra = $urandom_range(0, P - 1);
            rb = ra + $urandom_range(0, 40);
            if (rb == 0) rb = 1;
            load_now(1, ra, rb);
            run_n(3 * nval(ra, rb) + 40, 1);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule